// File: doc/BRIEF.md
# Converter Result Packer with Window Fault Strobe

This block sits between the result stream of an analog-to-digital converter and a DMA buffer port. Each accepted 12-bit conversion result is packed into a 16-bit word, with the sample right aligned. When tagging is switched on, the top nibble of the word carries the number of the channel that produced the sample, so software can sort a mixed buffer afterwards.

Every result is also tested against a programmable low/high window. A match sets a sticky compare flag that the register interface clears with a read-clear strobe. A match also fires a fault strobe, one clock wide, that is meant for the fault input of a PWM. The strobe is a separate signal from the flag: it pulses once for each matching result, whatever the state of the flag.

Top module: `sample_tag_packer`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in every other cycle.
- R2: On each `out_valid` cycle, `out_word[11:0]` equals the `in_sample` that was presented with the matching `in_valid`.
- R3: On each `out_valid` cycle, `out_word[15:12]` equals the `in_chan` of that result when `tag_en` was 1, and is 0 when `tag_en` was 0.
- R4: A result matches the window when `win_mode` is 0 and sample < `win_lo`; when it is 1 and sample > `win_hi`; when it is 2 and `win_lo` <= sample <= `win_hi`; when it is 3 and sample < `win_lo` or sample > `win_hi`.
- R5: `fault_pulse` is high for exactly the one cycle in which `out_valid` shows a matching result, and low in every other cycle.
- R6: Matching results on consecutive cycles give `fault_pulse` high on the same number of consecutive cycles.
- R7: `cmp_flag` goes high in the cycle of a fault pulse and stays high until it is cleared.
- R8: A `flag_clr` pulse clears `cmp_flag` from the next cycle on; if a matching result is accepted in the same cycle as `flag_clr`, the flag stays set.
- R9: During and after reset, `out_valid`, `out_word`, `cmp_flag` and `fault_pulse` are 0 until the first accepted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result strobe from the converter |
| in_sample | input | 12 | Conversion result |
| in_chan | input | 4 | Channel number of the result |
| tag_en | input | 1 | Put the channel number into the top nibble |
| win_mode | input | 2 | Window test: 0 below, 1 above, 2 inside, 3 outside |
| win_lo | input | 12 | Low window threshold |
| win_hi | input | 12 | High window threshold |
| flag_clr | input | 1 | Read-clear strobe for the compare flag |
| out_valid | output | 1 | Packed word valid toward the DMA buffer |
| out_word | output | 16 | Packed half-word |
| cmp_flag | output | 1 | Sticky compare-event flag |
| fault_pulse | output | 1 | One-clock fault strobe toward a PWM |

## Verification
The assertions take the reset for granted as the only source of initial state, and assume the converter holds `in_valid` low while reset is asserted, so that the first packed word after reset is always caused by a strobe seen after reset. They also assume `in_sample`, `in_chan` and `tag_en` are sampled only in cycles where `in_valid` is high. The stimulus drives all inputs one nanosecond after a rising edge, keeps `in_valid` low during reset, and mixes random samples, channels, modes and thresholds with directed cases at exactly `win_lo`, exactly `win_hi`, back-to-back matches and a clear that collides with a match.

// File: rtl/sample_tag_packer.sv
module sample_tag_packer #(
  parameter int SW = 12,
  parameter int CW = 4,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  input  logic [CW-1:0] in_chan,
  input  logic          tag_en,
  input  logic [1:0]    win_mode,
  input  logic [SW-1:0] win_lo,
  input  logic [SW-1:0] win_hi,
  input  logic          flag_clr,
  output logic          out_valid,
  output logic [OW-1:0] out_word,
  output logic          cmp_flag,
  output logic          fault_pulse
);

  logic below, above, hit;
  logic [OW-1:0] packed_w;

  assign below = in_sample < win_lo;
  assign above = in_sample > win_hi;

  always_comb begin
    case (win_mode)
      2'd0:    hit = below;
      2'd1:    hit = above;
      2'd2:    hit = !below && !above;
      default: hit = below || above;
    endcase
  end

  always_comb begin
    packed_w = '0;
    packed_w[SW-1:0] = in_sample;
    if (tag_en) packed_w[OW-1 -: CW] = in_chan;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      fault_pulse <= 1'b0;
      cmp_flag    <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      fault_pulse <= in_valid && hit;
      if (in_valid) out_word <= packed_w;
      if (in_valid && hit) cmp_flag <= 1'b1;
      else if (flag_clr)   cmp_flag <= 1'b0;
    end
  end

endmodule

module sample_tag_packer_chk #(
  parameter int SW = 12,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [SW-1:0] in_sample,
  input logic          tag_en,
  input logic          flag_clr,
  input logic          out_valid,
  input logic [OW-1:0] out_word,
  input logic          cmp_flag,
  input logic          fault_pulse
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_sample_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[SW-1:0] == $past(in_sample));
  assert_untagged_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tag_en) |=> out_word[OW-1:SW] == '0);
  assert_fault_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> out_valid);
  assert_flag_with_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> cmp_flag);
  assert_flag_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag) |-> $past(flag_clr));

endmodule

bind sample_tag_packer sample_tag_packer_chk #(.SW(SW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .tag_en(tag_en), .flag_clr(flag_clr), .out_valid(out_valid),
  .out_word(out_word), .cmp_flag(cmp_flag), .fault_pulse(fault_pulse)
);

// File: tb/tb_sample_tag_packer.sv
`timescale 1ns/1ps
module tb_sample_tag_packer;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, tag_en = 0, flag_clr = 0;
  logic [11:0] in_sample = 0, win_lo = 0, win_hi = 0;
  logic [3:0] in_chan = 0;
  logic [1:0] win_mode = 0;
  logic out_valid, cmp_flag, fault_pulse;
  logic [15:0] out_word;

  int total = 0, bad = 0;
  bit done = 0;
  logic e_valid = 0, e_fault = 0, e_flag = 0;
  logic [15:0] e_word = 0;

  always #5 clk = ~clk;

  sample_tag_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .tag_en(tag_en), .win_mode(win_mode), .win_lo(win_lo),
    .win_hi(win_hi), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_word(out_word), .cmp_flag(cmp_flag), .fault_pulse(fault_pulse)
  );

  function automatic bit in_window(logic [1:0] m, logic [11:0] s, logic [11:0] lo, logic [11:0] hi);
    case (m)
      2'd0: return s < lo;
      2'd1: return s > hi;
      2'd2: return s >= lo && s <= hi;
      default: return s < lo || s > hi;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [11:0] s, logic [3:0] c, logic t, logic [1:0] m,
                      logic [11:0] lo, logic [11:0] hi, logic clr, string fr, string gr);
    bit h;
    in_valid = v; in_sample = s; in_chan = c; tag_en = t;
    win_mode = m; win_lo = lo; win_hi = hi; flag_clr = clr;
    h = v && in_window(m, s, lo, hi);
    e_valid = v;
    if (v) e_word = {t ? c : 4'h0, s};
    e_fault = h;
    if (h) e_flag = 1'b1; else if (clr) e_flag = 1'b0;
    @(posedge clk); #1;
    check("R1 valid", {15'd0, out_valid}, {15'd0, e_valid});
    check("R2 low bits", {4'd0, out_word[11:0]}, {4'd0, e_word[11:0]});
    check("R3 top bits", {12'd0, out_word[15:12]}, {12'd0, e_word[15:12]});
    check(fr, {15'd0, fault_pulse}, {15'd0, e_fault});
    check(gr, {15'd0, cmp_flag}, {15'd0, e_flag});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {15'd0, out_valid}, 16'd0);
    check("R9 reset word", out_word, 16'd0);
    check("R9 reset flag", {15'd0, cmp_flag}, 16'd0);
    check("R9 reset fault", {15'd0, fault_pulse}, 16'd0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle fault", "R9 idle flag");
    // R4 boundaries: lo=100, hi=200
    step(1, 12'd100, 4'd3, 1, 2'd0, 12'd100, 12'd200, 0, "R4 below at lo", "R7 flag");
    step(1, 12'd99,  4'd3, 1, 2'd0, 12'd100, 12'd200, 0, "R4 below lo-1", "R7 flag");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R5 idle", "R8 clear");
    step(1, 12'd200, 4'd9, 0, 2'd1, 12'd100, 12'd200, 0, "R4 above at hi", "R7 flag");
    step(1, 12'd201, 4'd9, 0, 2'd1, 12'd100, 12'd200, 0, "R4 above hi+1", "R7 flag");
    step(1, 12'd100, 4'd1, 1, 2'd2, 12'd100, 12'd200, 1, "R4 inside at lo", "R8 set wins");
    step(1, 12'd200, 4'd2, 1, 2'd2, 12'd100, 12'd200, 0, "R6 back-to-back", "R7 flag");
    step(1, 12'd150, 4'd4, 1, 2'd2, 12'd100, 12'd200, 0, "R6 back-to-back", "R7 flag");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R5 single pulse end", "R8 clear");
    step(1, 12'd150, 4'd5, 1, 2'd3, 12'd100, 12'd200, 0, "R4 outside no hit", "R8 stays clear");
    step(1, 12'd201, 4'hF, 1, 2'd3, 12'd100, 12'd200, 0, "R4 outside hit", "R7 flag");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5 idle", "R7 sticky");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5 idle", "R7 sticky");
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a, b;
      a = 12'($urandom); b = 12'($urandom);
      step(($urandom % 4) != 0, 12'($urandom), 4'($urandom), 1'($urandom),
           2'($urandom), a < b ? a : b, a < b ? b : a, ($urandom % 8) == 0,
           "R5 random fault", "R7 random flag");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule